// File: doc/BRIEF.md
# I2C Master Read Engine

This block is the receive half of an I2C bus master. A single command names a 7-bit target address, whether to open with a START, whether to close with a STOP, and how many bytes to read. The engine puts the address with the read bit on the bus and clocks in the requested bytes. Each byte lands in one receive holding register, and a ready flag is raised. That flag can serve software polling or act as the request line of a receive DMA channel.

The bus lines are modelled as open-drain: `scl_oe` and `sda_oe` pull the line low when high, and the resolved SDA level returns on `sda_in`. When the holding register has not been read by the time the next byte is due, the master keeps SCL low until it is read. A command with a zero byte count reduces to an address probe.

A command may end without a STOP. The master then keeps SCL low and owns the bus. A later command can issue a repeated START, or it can carry on reading without a new address.

Top module: `i2c_rd_master`

## Requirements
- R1: After reset, `idle`=1, `rx_ready`=0, `nack_err`=0, `scl_oe`=0 and `sda_oe`=0.
- R2: A command with `cmd_start`=1 produces a START (SDA falls while SCL is high). It then sends eight bits MSB first: the 7-bit address followed by a 1 (read). SDA changes only while SCL is low, except during START and STOP.
- R3: Each bit spans four quarter periods of `quarter_div`+1 clock cycles, and SCL is high for 2·(`quarter_div`+1) cycles per bit.
- R4: Before each data byte after the first, while `rx_ready` is still 1, SCL is held low with no clock pulse other than the acknowledge clock of the byte just received. Clocking resumes once `rhr_read` has cleared the flag.
- R5: Each received byte (MSB first) appears on `rhr_data` and sets `rx_ready`. A one-cycle `rhr_read` pulse clears `rx_ready` on the next clock.
- R6: The master drives ACK (SDA low) on the ninth clock of every byte except the last of the programmed count. On the last byte it leaves SDA released (NAK).
- R7: `idle` goes low the cycle after a command is accepted. With `cmd_stop`=1, a STOP follows the last NAK, and then `idle` returns high with both lines released.
- R8: `cmd_start`=1, `cmd_stop`=1 and `cmd_count`=0 give START, address with read bit, the acknowledge slot, then STOP, with no data byte and no `rx_ready`.
- R9: If the address is not acknowledged, the engine issues a STOP, reads no data and sets `nack_err`. The next accepted command clears `nack_err`.
- R10: With `cmd_stop`=0, after the last byte `idle` is 1 while SCL stays held low. A following command with `cmd_start`=1 generates a repeated START.
- R11: A command with `cmd_start`=0 is accepted only while the bus is held. It then reads `cmd_count` further bytes with no START and no address. From a free bus such a command is discarded and no bus activity follows.
- R12: `cmd_valid` while `idle`=0 is ignored and does not alter the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_addr | input | 7 | Target address |
| cmd_start | input | 1 | Begin with START and address |
| cmd_stop | input | 1 | End with STOP |
| cmd_count | input | CNT_W | Number of bytes to read |
| quarter_div | input | DIV_W | Quarter bit period minus one, in clock cycles |
| rhr_read | input | 1 | Read strobe for the holding register |
| rhr_data | output | 8 | Receive holding register |
| rx_ready | output | 1 | Holding register full / DMA request |
| idle | output | 1 | No transfer in progress |
| nack_err | output | 1 | Address was not acknowledged |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Resolved SDA level |

## Verification
`idle` falls one clock after the command strobe, and `rx_ready` falls one clock after the `rhr_read` pulse. The bench samples each of these at the next falling edge after the strobe's active edge. A received byte is due only after nine bit periods of four quarters. For that reason the bench waits for `rx_ready` and then holds off 40 to 100 cycles, which is longer than one bit period, before it compares the byte and confirms that exactly one acknowledge clock occurred during the wait. Bus-level results are taken from a slave model driven by SCL and SDA edges, and are compared once `idle` is back high: ACK pattern, address, and START/STOP counts.

// File: rtl/i2c_rd_master.sv
module i2c_rd_master #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [6:0]       cmd_addr,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic [DIV_W-1:0] quarter_div,
  input  logic             rhr_read,
  output logic [7:0]       rhr_data,
  output logic             rx_ready,
  output logic             idle,
  output logic             nack_err,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_START, ST_ADDR, ST_WAIT, ST_DATA, ST_STOP
  } state_t;

  state_t           st;
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic [DIV_W-1:0] divc;
  logic [CNT_W-1:0] cnt;
  logic             stop_f;
  logic [7:0]       addr_sh;
  logic [7:0]       rx_sh;
  logic             addr_nak;
  logic             scl_r, sda_r, rdy, nerr;
  logic [7:0]       rhr;

  logic running, tick, last, accept;

  assign running = st inside {ST_START, ST_ADDR, ST_DATA, ST_STOP};
  assign tick    = running && (divc == quarter_div);
  assign last    = (cnt == CNT_W'(1));
  assign idle    = (st == ST_IDLE) || (st == ST_HOLD);
  assign accept  = cmd_valid && idle && (cmd_start || st == ST_HOLD);

  assign rhr_data = rhr;
  assign rx_ready = rdy;
  assign nack_err = nerr;
  assign scl_oe   = scl_r;
  assign sda_oe   = sda_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      q        <= 2'd0;
      bitn     <= 4'd0;
      divc     <= '0;
      cnt      <= '0;
      stop_f   <= 1'b0;
      addr_sh  <= 8'd0;
      rx_sh    <= 8'd0;
      addr_nak <= 1'b0;
      scl_r    <= 1'b0;
      sda_r    <= 1'b0;
      rdy      <= 1'b0;
      nerr     <= 1'b0;
      rhr      <= 8'd0;
    end else begin
      divc <= (!running || tick) ? '0 : divc + 1'b1;
      if (rhr_read) rdy <= 1'b0;

      if (accept) begin
        nerr    <= 1'b0;
        addr_sh <= {cmd_addr, 1'b1};
        cnt     <= cmd_count;
        stop_f  <= cmd_stop;
        q       <= 2'd0;
        bitn    <= 4'd0;
        if (cmd_start)            st <= ST_START;
        else if (cmd_count != '0) st <= ST_WAIT;
        else if (cmd_stop)        st <= ST_STOP;
      end else if (st == ST_WAIT) begin
        if (!rdy) begin
          st   <= ST_DATA;
          q    <= 2'd0;
          bitn <= 4'd0;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (st)
          ST_START: begin
            case (q)
              2'd0: scl_r <= 1'b0;
              2'd1: sda_r <= 1'b1;
              2'd3: begin
                scl_r <= 1'b1;
                st    <= ST_ADDR;
                bitn  <= 4'd0;
              end
              default: ;
            endcase
          end
          ST_ADDR: begin
            case (q)
              2'd0: sda_r <= bitn[3] ? 1'b0 : ~addr_sh[7];
              2'd1: scl_r <= 1'b0;
              2'd2: if (bitn[3]) addr_nak <= sda_in;
              default: begin
                scl_r   <= 1'b1;
                addr_sh <= {addr_sh[6:0], 1'b0};
                if (!bitn[3]) bitn <= bitn + 4'd1;
                else if (addr_nak) begin
                  nerr <= 1'b1;
                  st   <= ST_STOP;
                end
                else if (cnt != '0) st <= ST_WAIT;
                else if (stop_f)    st <= ST_STOP;
                else                st <= ST_HOLD;
              end
            endcase
          end
          ST_DATA: begin
            case (q)
              2'd0: sda_r <= bitn[3] && !last;
              2'd1: scl_r <= 1'b0;
              2'd2: if (!bitn[3]) rx_sh <= {rx_sh[6:0], sda_in};
              default: begin
                scl_r <= 1'b1;
                if (bitn == 4'd7) begin
                  rhr <= rx_sh;
                  rdy <= 1'b1;
                end
                if (!bitn[3]) bitn <= bitn + 4'd1;
                else begin
                  cnt <= cnt - 1'b1;
                  if (!last)       st <= ST_WAIT;
                  else if (stop_f) st <= ST_STOP;
                  else             st <= ST_HOLD;
                end
              end
            endcase
          end
          ST_STOP: begin
            case (q)
              2'd0: sda_r <= 1'b1;
              2'd1: scl_r <= 1'b0;
              2'd2: sda_r <= 1'b0;
              default: st <= ST_IDLE;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  AST_FREE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!scl_oe && !sda_oe)); // R1

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_ADDR || st == ST_DATA) && $past(st) == st && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe)); // R2

  AST_STRETCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && rx_ready) |=> scl_oe); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_read && st == ST_WAIT) |=> !rx_ready); // R5

  AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && bitn == 4'd8 && q == 2'd2) |-> (sda_oe == (cnt != CNT_W'(1)))); // R6

  AST_NAK_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> (st == ST_STOP)); // R9

endmodule

// File: tb/sim_i2c_rd_master.sv
module sim_i2c_rd_master;
  localparam int CNT_W = 8;
  localparam int DIV_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             cmd_valid = 1'b0;
  logic [6:0]       cmd_addr = 7'd0;
  logic             cmd_start = 1'b0, cmd_stop = 1'b0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic [DIV_W-1:0] qdiv = 12'd3;
  logic             rhr_read = 1'b0;
  logic [7:0]       rhr_data;
  logic             rx_ready, idle, nack_err, scl_oe, sda_oe;
  logic             slv_low = 1'b0;

  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_low);

  i2c_rd_master #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_count(cmd_count),
    .quarter_div(qdiv), .rhr_read(rhr_read), .rhr_data(rhr_data),
    .rx_ready(rx_ready), .idle(idle), .nack_err(nack_err),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ack(input int i, input int n);
    return i < n - 1;
  endfunction

  // slave model
  logic [7:0] sdata [16];
  logic [6:0] slv_addr = 7'd0;
  bit   addr_en = 1'b1;
  int   phase = 0, sbit = 0, bi = 0, nrec = 0, starts = 0, stops = 0;
  logic [7:0] sh = 8'd0, got_addr = 8'd0;
  bit   acked = 1'b0;
  bit   acklog [16];
  logic pscl = 1'b1, psda = 1'b1;

  always @(scl_line or sda_line) begin
    if (scl_line && pscl && psda && !sda_line) begin
      starts++; phase = 1; sbit = 0;
    end else if (scl_line && pscl && !psda && sda_line) begin
      stops++; phase = 0;
    end else if (scl_line && !pscl) begin
      if (phase == 1) begin
        if (sbit < 8) begin
          sh = {sh[6:0], sda_line};
          if (sbit == 7) got_addr = sh;
          sbit++;
        end else begin
          phase = acked ? 2 : 0; sbit = 0;
        end
      end else if (phase == 2) begin
        if (sbit < 8) sbit++;
        else begin
          acklog[nrec % 16] = !sda_line;
          nrec++; bi++; sbit = 0;
          if (sda_line) phase = 0;
        end
      end
    end else if (!scl_line && pscl) begin
      if (phase == 1 && sbit == 8) begin
        acked = addr_en && (got_addr == {slv_addr, 1'b1});
        slv_low <= acked;
      end else if (phase == 2 && sbit < 8)
        slv_low <= ~sdata[bi % 16][3'(7 - sbit)];
      else
        slv_low <= 1'b0;
    end
    pscl = scl_line;
    psda = sda_line;
  end

  // SCL monitors
  int hi = 0, hi_last = 0, rises = 0, cyc = 0;
  logic scl_q = 1'b1;
  always @(posedge clk) begin
    if (scl_line) hi <= hi + 1;
    else begin
      if (hi != 0) hi_last <= hi;
      hi <= 0;
    end
    if (scl_line && !scl_q) rises <= rises + 1;
    scl_q <= scl_line;
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_xfer(input logic [6:0] a, input bit st, input bit sp, input int n,
                         input bit aen, input bit held, input bit poke);
    int s0, p0, r0;
    logic [7:0] e;
    slv_addr = a; addr_en = aen; nrec = 0; bi = 0;
    for (int i = 0; i < 16; i++) sdata[i] = 8'($urandom);
    if (n == 0) sdata[0] = 8'hFF;
    s0 = starts; p0 = stops;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_start = st; cmd_stop = sp; cmd_count = n[7:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 idle low once command taken", idle, 0);
    chk("R9 error flag cleared by new command", nack_err, 0);
    for (int i = 0; i < n && aen; i++) begin
      while (!rx_ready) @(negedge clk);
      r0 = rises;
      if (poke && i == 0) begin
        cmd_valid = 1'b1; cmd_addr = ~a; cmd_start = 1'b1; cmd_stop = 1'b1; cmd_count = 8'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
      repeat (40 + $urandom % 60) @(negedge clk);
      e = held ? 8'hFF : sdata[i];
      chk(held ? "R11 continued byte" : "R5 received byte", rhr_data, e);
      if (i < n - 1) begin
        chk("R4 SCL held low while register full", scl_oe, 1);
        chk("R4 only ack clock while register full", rises - r0, 1);
        chk("R3 SCL high time", hi_last, 2 * (qdiv + 1));
      end
      rhr_read = 1'b1;
      @(negedge clk);
      rhr_read = 1'b0;
      chk("R5 read clears ready", rx_ready, 0);
    end
    while (!idle) @(negedge clk);
    @(negedge clk);
    chk("R2 START count", starts - s0, st ? 1 : 0);
    if (st) chk("R2 address and read bit", got_addr, {a, 1'b1});
    chk("R7 STOP count", stops - p0, (sp || !aen) ? 1 : 0);
    if (!aen) begin
      chk("R9 address NAK flag", nack_err, 1);
      chk("R9 no data after NAK", rx_ready, 0);
    end
    if (aen && !held) begin
      chk("R6 acknowledge slots", nrec, n);
      for (int i = 0; i < n && i < 16; i++)
        chk("R6 ACK/NAK pattern", acklog[i], exp_ack(i, n));
    end
    if (n == 0) chk("R8 probe has no data", rx_ready, 0);
    if (aen && !sp) begin
      chk("R10 bus held after transfer", scl_oe, 1);
      chk("R10 idle while held", idle, 1);
    end
    if (sp || !aen) chk("R7 lines released after STOP", {scl_oe, sda_oe}, 2'b00);
    if (poke) chk("R12 busy command ignored", starts - s0, 1);
  endtask

  initial begin
    int s0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 reset idle", idle, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset idle", idle, 1);
    chk("R1 reset ready", rx_ready, 0);
    chk("R1 reset error", nack_err, 0);
    chk("R1 reset lines", {scl_oe, sda_oe}, 2'b00);

    do_xfer(7'h50, 1, 1, 1, 1, 0, 0);
    do_xfer(7'h2A, 1, 1, 4, 1, 0, 1);
    do_xfer(7'h11, 1, 1, 0, 1, 0, 0);
    do_xfer(7'h33, 1, 1, 3, 0, 0, 0);

    s0 = starts;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_start = 1'b0; cmd_stop = 1'b1; cmd_count = 8'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (50) @(negedge clk);
    chk("R11 no-START command ignored on free bus", idle, 1);
    chk("R11 no bus activity", {scl_oe, sda_oe}, 2'b00);
    chk("R11 no START issued", starts - s0, 0);

    do_xfer(7'h44, 1, 0, 2, 1, 0, 0);
    do_xfer(7'h44, 0, 0, 1, 1, 1, 0);
    do_xfer(7'h44, 1, 1, 2, 1, 0, 0);

    for (int k = 0; k < 8; k++) begin
      qdiv = 12'(1 + $urandom % 6);
      do_xfer(7'($urandom), 1, 1, 1 + $urandom % 5, ($urandom % 5) != 0, 0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule